// File: doc/BRIEF.md
# Memory-Resident Translation Buffer Probe Engine

This block performs one lookup in a large shared translation buffer that is kept in ordinary memory rather than in on-chip storage. The buffer is split into two regions, one holding 4KB translations and one holding 2MB translations, each starting at its own base address. Each region is organised as four-way sets, and each set is packed into a single 64-byte memory line.

A caller presents a virtual page number, an address space ID, a VM ID and a guess of the page-size class. The engine turns the page number into a set address in the guessed region and issues one line read. It then compares all four ways of the returned line at once. If one of them matches, it returns the physical page number and attributes. If none matches, it repeats the probe in the other region. When both regions miss, it reports that a page walk is needed. The response also says which class supplied the hit and whether that was the second probe, so the caller can train its size predictor.

Top module: `mtlb_probe`

## Requirements
- R1: A line holds way w in bits [128w+127:128w]. Within an entry, from MSB to LSB, the fields are: valid bit 127, VM ID bits 126:111, ASID bits 110:95, attributes bits 94:76, PPN bits 75:36 and VPN bits 35:0. A way matches only if it is valid and its ASID and VM ID both equal the request's. In the 4KB region all 36 VPN bits must also be equal. In the 2MB region only VPN bits 35:9 are compared.
- R2: When more than one way matches, the lowest-numbered way supplies the result.
- R3: The probe address is the region base plus 64 times the set index. The set index is VPN[9:0] in the 4KB region and VPN[18:9] in the 2MB region. Consecutive sets are therefore 64 bytes apart, so one 2KB row holds 32 of them.
- R4: Each probe issues exactly one memory read. The address is held stable while `mem_req_valid` waits for `mem_req_ready`. No further read starts until the response has returned.
- R5: The first probe goes to the predicted class, where `req_huge_pred`=1 means 2MB. A hit on the first probe ends the lookup after one read, and `rsp_second`=0.
- R6: A miss on the first probe is followed by a probe of the other class. A hit there gives `rsp_second`=1, and `rsp_huge` names that other class.
- R7: If both classes miss, the response has `rsp_walk`=1 and `rsp_hit`=0 after exactly two reads, with `rsp_second`=1.
- R8: On a hit, `rsp_ppn` and `rsp_attr` equal the fields of the selected entry, and `rsp_huge` is 1 when that entry came from the 2MB region.
- R9: After reset, `req_ready` is 1 and `rsp_valid` and `mem_req_valid` are 0. `req_ready` is 1 only while no lookup is in progress. A response stays valid and unchanged until `rsp_ready` is seen, and then drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Engine idle and able to accept a request |
| req_vpn | input | 36 | Virtual page number |
| req_asid | input | 16 | Address space ID |
| req_vmid | input | 16 | VM ID |
| req_huge_pred | input | 1 | Predicted class: 1 = 2MB, 0 = 4KB |
| mem_req_valid | output | 1 | Line read request valid |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 48 | Byte address of the 64-byte set line |
| mem_rsp_valid | input | 1 | Line data valid, one pulse per read |
| mem_rsp_data | input | 512 | Returned set line |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_ready | input | 1 | Caller accepts the result |
| rsp_hit | output | 1 | Translation found |
| rsp_walk | output | 1 | Both classes missed; a page walk is needed |
| rsp_ppn | output | 40 | Physical page number of the hit |
| rsp_attr | output | 19 | Attribute bits of the hit |
| rsp_huge | output | 1 | Class of the final probe: 1 = 2MB |
| rsp_second | output | 1 | Result came from the second probe |

## Verification
Directed lookups cover four placements against each guess: a hit in the predicted class only, a hit in the other class only, a hit in both classes, and a miss in both. These cases separate the one-read path from the two-read path and confirm that a walk is raised only after both reads. Decoy entries are placed next to the true match: one invalid, one with the wrong ASID, one with the wrong VM ID, a copy in a higher way, and a 4KB entry whose VPN differs only in bit 0. They show that each field takes part in the match, that the lowest way wins, and that only the 2MB class ignores VPN[8:0]. Random lookups add memory and caller stalls. Every issued address is checked against the set-index formula for the class expected at that point in the order.

// File: rtl/mtlb_pkg.sv
// Shared widths, entry layout and state encoding for the memory-resident
// translation buffer probe engine. One set of WAYS entries fills a line.
package mtlb_pkg;
    localparam int VPN_W    = 36;
    localparam int PPN_W    = 40;
    localparam int ATTR_W   = 19;
    localparam int ASID_W   = 16;
    localparam int VMID_W   = 16;
    localparam int WAYS     = 4;
    localparam int ENTRY_W  = 1 + VMID_W + ASID_W + ATTR_W + PPN_W + VPN_W;
    localparam int LINE_W   = ENTRY_W * WAYS;
    localparam int OFFSET_W = $clog2(LINE_W / 8);

    // Entry fields, declared MSB first.
    typedef struct packed {
        logic              valid;
        logic [VMID_W-1:0] vmid;
        logic [ASID_W-1:0] asid;
        logic [ATTR_W-1:0] attr;
        logic [PPN_W-1:0]  ppn;
        logic [VPN_W-1:0]  vpn;
    } entry_t;

    typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT, ST_RESP} state_t;
endpackage

// File: rtl/mtlb_set_addr.sv
// Set address generator: picks the region base for the class being probed
// and adds the line-sized offset of the set index taken from the VPN.
// Assumes both bases are line aligned and that each region spans 2^SET_BITS lines.
module mtlb_set_addr
    import mtlb_pkg::*;
#(
    parameter int                ADDR_W     = 48,
    parameter logic [ADDR_W-1:0] SMALL_BASE = 48'h0000_4000_0000,
    parameter logic [ADDR_W-1:0] HUGE_BASE  = 48'h0000_8000_0000,
    parameter int                SET_BITS   = 10,
    parameter int                HUGE_SHIFT = 9
) (
    input  logic [VPN_W-1:0]  vpn,
    input  logic              huge,
    output logic [ADDR_W-1:0] addr
);
    logic [SET_BITS-1:0] idx;
    logic [ADDR_W-1:0]   base;

    // Select the index bits and base for the class, then form the line address.
    always_comb begin
        idx  = huge ? vpn[HUGE_SHIFT +: SET_BITS] : vpn[0 +: SET_BITS];
        base = huge ? HUGE_BASE : SMALL_BASE;
        addr = base + (ADDR_W'(idx) << OFFSET_W);
    end
endmodule

// File: rtl/mtlb_way_match.sv
// Parallel way comparator: unpacks one set line into its WAYS entries,
// compares each against the request tags and picks the lowest matching way.
// In the large-page class the low HUGE_SHIFT VPN bits do not take part.
module mtlb_way_match
    import mtlb_pkg::*;
#(
    parameter int HUGE_SHIFT = 9
) (
    input  logic [LINE_W-1:0] line,
    input  logic [VPN_W-1:0]  vpn,
    input  logic [ASID_W-1:0] asid,
    input  logic [VMID_W-1:0] vmid,
    input  logic              huge,
    output logic              hit,
    output logic [PPN_W-1:0]  ppn,
    output logic [ATTR_W-1:0] attr
);
    localparam logic [VPN_W-1:0] HUGE_MASK = {VPN_W{1'b1}} << HUGE_SHIFT;

    entry_t [WAYS-1:0] ways;
    logic   [WAYS-1:0] match;
    logic   [VPN_W-1:0] vmask;
    entry_t            sel;

    assign ways  = line;
    assign vmask = huge ? HUGE_MASK : {VPN_W{1'b1}};

    // One comparator per way, all evaluated in the same cycle.
    for (genvar g = 0; g < WAYS; g++) begin : g_way
        assign match[g] = ways[g].valid
                       && (((ways[g].vpn ^ vpn) & vmask) == '0)
                       && (ways[g].asid == asid)
                       && (ways[g].vmid == vmid);
    end

    // Priority select: scanning downward leaves the lowest matching way.
    always_comb begin
        hit = 1'b0;
        sel = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match[w]) begin
                hit = 1'b1;
                sel = ways[w];
            end
        end
        ppn  = sel.ppn;
        attr = sel.attr;
    end

    // The selected entry must itself satisfy every match condition.
    always_comb begin
        if (hit) begin
            assert_hit_valid_R1: assert (sel.valid && sel.asid == asid && sel.vmid == vmid
                                         && (((sel.vpn ^ vpn) & vmask) == '0));
        end
    end
endmodule

// File: rtl/mtlb_probe.sv
// Probe engine top: accepts one lookup while idle and reads the set line of
// the predicted class. On a miss it reads the line of the other class, and
// when both miss it reports that a page walk is needed. The result is held
// until the caller accepts it. Assumes memory returns exactly one
// mem_rsp_valid pulse per accepted read and is always ready to deliver it.
module mtlb_probe
    import mtlb_pkg::*;
#(
    parameter int                ADDR_W     = 48,
    parameter logic [ADDR_W-1:0] SMALL_BASE = 48'h0000_4000_0000,
    parameter logic [ADDR_W-1:0] HUGE_BASE  = 48'h0000_8000_0000,
    parameter int                SET_BITS   = 10,
    parameter int                HUGE_SHIFT = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VPN_W-1:0]  req_vpn,
    input  logic [ASID_W-1:0] req_asid,
    input  logic [VMID_W-1:0] req_vmid,
    input  logic              req_huge_pred,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [LINE_W-1:0] mem_rsp_data,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic              rsp_hit,
    output logic              rsp_walk,
    output logic [PPN_W-1:0]  rsp_ppn,
    output logic [ATTR_W-1:0] rsp_attr,
    output logic              rsp_huge,
    output logic              rsp_second
);
    state_t            state;
    logic              cur_huge;
    logic              second;
    logic [VPN_W-1:0]  lat_vpn;
    logic [ASID_W-1:0] lat_asid;
    logic [VMID_W-1:0] lat_vmid;
    logic              m_hit;
    logic [PPN_W-1:0]  m_ppn;
    logic [ATTR_W-1:0] m_attr;
    logic              r_hit;
    logic [PPN_W-1:0]  r_ppn;
    logic [ATTR_W-1:0] r_attr;
    logic              r_huge;
    logic              r_second;

    mtlb_set_addr #(
        .ADDR_W(ADDR_W), .SMALL_BASE(SMALL_BASE), .HUGE_BASE(HUGE_BASE),
        .SET_BITS(SET_BITS), .HUGE_SHIFT(HUGE_SHIFT)
    ) u_addr (
        .vpn(lat_vpn), .huge(cur_huge), .addr(mem_req_addr)
    );

    mtlb_way_match #(.HUGE_SHIFT(HUGE_SHIFT)) u_match (
        .line(mem_rsp_data), .vpn(lat_vpn), .asid(lat_asid), .vmid(lat_vmid),
        .huge(cur_huge), .hit(m_hit), .ppn(m_ppn), .attr(m_attr)
    );

    assign req_ready     = (state == ST_IDLE);
    assign mem_req_valid = (state == ST_ISSUE);
    assign rsp_valid     = (state == ST_RESP);
    assign rsp_hit       = r_hit;
    assign rsp_walk      = rsp_valid && !r_hit;
    assign rsp_ppn       = r_ppn;
    assign rsp_attr      = r_attr;
    assign rsp_huge      = r_huge;
    assign rsp_second    = r_second;

    // Lookup sequencer: issue, wait, retry the other class, hold the result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cur_huge <= 1'b0;
            second   <= 1'b0;
            lat_vpn  <= '0;
            lat_asid <= '0;
            lat_vmid <= '0;
            r_hit    <= 1'b0;
            r_ppn    <= '0;
            r_attr   <= '0;
            r_huge   <= 1'b0;
            r_second <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (req_valid) begin
                    lat_vpn  <= req_vpn;
                    lat_asid <= req_asid;
                    lat_vmid <= req_vmid;
                    cur_huge <= req_huge_pred;
                    second   <= 1'b0;
                    state    <= ST_ISSUE;
                end
                ST_ISSUE: if (mem_req_ready) state <= ST_WAIT;
                ST_WAIT: if (mem_rsp_valid) begin
                    if (m_hit) begin
                        r_hit    <= 1'b1;
                        r_ppn    <= m_ppn;
                        r_attr   <= m_attr;
                        r_huge   <= cur_huge;
                        r_second <= second;
                        state    <= ST_RESP;
                    end else if (!second) begin
                        second   <= 1'b1;
                        cur_huge <= ~cur_huge;
                        state    <= ST_ISSUE;
                    end else begin
                        r_hit    <= 1'b0;
                        r_ppn    <= '0;
                        r_attr   <= '0;
                        r_huge   <= cur_huge;
                        r_second <= 1'b1;
                        state    <= ST_RESP;
                    end
                end
                ST_RESP: if (rsp_ready) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // A stalled read request keeps its address.
    assert_mem_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

    // An accepted read is not followed at once by another request.
    assert_one_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && mem_req_ready |=> !mem_req_valid);

    // A stalled response keeps every field.
    assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_hit) && $stable(rsp_ppn)
                                    && $stable(rsp_attr) && $stable(rsp_huge) && $stable(rsp_second));

    // A walk is requested only after the second class was probed.
    assert_walk_second_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_walk |-> rsp_second);

    // No memory traffic is started while a result is being offered.
    assert_quiet_resp_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !mem_req_valid && !req_ready);
endmodule

// File: tb/sim_mtlb_probe.sv
// Bench for the probe engine: directed placements plus seeded random lookups
// against a stalling memory model. Expected results come from bench functions.
module sim_mtlb_probe;
    import mtlb_pkg::*;

    localparam logic [47:0] SB = 48'h0000_4000_0000;
    localparam logic [47:0] HB = 48'h0000_8000_0000;

    logic              clk, rst_n;
    logic              req_valid, req_ready, req_huge_pred;
    logic [VPN_W-1:0]  req_vpn;
    logic [ASID_W-1:0] req_asid;
    logic [VMID_W-1:0] req_vmid;
    logic              mem_req_valid, mem_req_ready, mem_rsp_valid;
    logic [47:0]       mem_req_addr;
    logic [LINE_W-1:0] mem_rsp_data;
    logic              rsp_valid, rsp_ready, rsp_hit, rsp_walk, rsp_huge, rsp_second;
    logic [PPN_W-1:0]  rsp_ppn;
    logic [ATTR_W-1:0] rsp_attr;

    mtlb_probe #(.SMALL_BASE(SB), .HUGE_BASE(HB)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_vpn(req_vpn), .req_asid(req_asid), .req_vmid(req_vmid),
        .req_huge_pred(req_huge_pred), .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_hit(rsp_hit),
        .rsp_walk(rsp_walk), .rsp_ppn(rsp_ppn), .rsp_attr(rsp_attr),
        .rsp_huge(rsp_huge), .rsp_second(rsp_second)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    int reads;
    logic [47:0] rec_addr [4];
    logic [LINE_W-1:0] line_s, line_h;

    // Count one check and report it when it miscompares.
    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic entry_t mk(input logic v, input logic [15:0] vm, input logic [15:0] as,
                                  input logic [18:0] at, input logic [39:0] pp, input logic [35:0] vp);
        entry_t e;
        e.valid = v; e.vmid = vm; e.asid = as; e.attr = at; e.ppn = pp; e.vpn = vp;
        return e;
    endfunction

    function automatic logic [35:0] rnd36();
        logic [63:0] r;
        r = {$urandom(), $urandom()};
        return r[35:0];
    endfunction

    function automatic entry_t rnd_entry();
        return mk(1'($urandom()), 16'($urandom()), 16'($urandom()), 19'($urandom()),
                  {8'($urandom()), 32'($urandom())}, rnd36());
    endfunction

    // R3: base plus 64 times the class-specific set index.
    function automatic logic [47:0] exp_addr(input logic [35:0] v, input bit huge);
        logic [47:0] idx;
        idx = huge ? 48'(v[18:9]) : 48'(v[9:0]);
        return (huge ? HB : SB) + idx * 48'd64;
    endfunction

    // R1/R2: lowest way whose valid bit and tags match, or -1.
    function automatic int find(input logic [LINE_W-1:0] ln, input logic [35:0] v,
                                input logic [15:0] a, input logic [15:0] m, input bit huge);
        entry_t e;
        logic [35:0] msk;
        msk = huge ? {{27{1'b1}}, 9'b0} : {36{1'b1}};
        for (int w = 0; w < WAYS; w++) begin
            e = ln[w*ENTRY_W +: ENTRY_W];
            if (e.valid && (((e.vpn ^ v) & msk) == 36'd0) && e.asid == a && e.vmid == m)
                return w;
        end
        return -1;
    endfunction

    function automatic entry_t way_of(input logic [LINE_W-1:0] ln, input int w);
        return ln[w*ENTRY_W +: ENTRY_W];
    endfunction

    task automatic fill_random();
        for (int w = 0; w < WAYS; w++) begin
            line_s[w*ENTRY_W +: ENTRY_W] = rnd_entry();
            line_h[w*ENTRY_W +: ENTRY_W] = rnd_entry();
        end
    endtask

    // Memory model: random accept stall and latency, returns the line by address.
    initial begin
        mem_req_ready = 1'b0;
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = '0;
        forever begin
            @(negedge clk);
            if (rst_n && mem_req_valid) begin
                logic [47:0] a;
                a = mem_req_addr;
                repeat ($urandom() % 3) @(negedge clk);
                mem_req_ready = 1'b1;
                @(negedge clk);
                mem_req_ready = 1'b0;
                if (reads < 4) rec_addr[reads] = a;
                reads++;
                repeat ($urandom() % 4) @(negedge clk);
                if (a == exp_addr(req_vpn, 1'b0)) mem_rsp_data = line_s;
                else if (a == exp_addr(req_vpn, 1'b1)) mem_rsp_data = line_h;
                else mem_rsp_data = '0;
                mem_rsp_valid = 1'b1;
                @(negedge clk);
                mem_rsp_valid = 1'b0;
            end
        end
    end

    // One lookup with full checking of order, reads and the held result.
    task automatic run(input logic [35:0] v, input logic [15:0] a, input logic [15:0] m,
                       input bit pred, input string tag);
        int fp, fo, exp_reads, waited;
        bit e_hit, e_huge, e_second;
        entry_t e;
        logic [PPN_W-1:0] s_ppn;
        fp = find(pred ? line_h : line_s, v, a, m, pred);
        fo = find(pred ? line_s : line_h, v, a, m, !pred);
        e = '0;
        if (fp >= 0) begin
            e_hit = 1; e_huge = pred; e_second = 0; exp_reads = 1;
            e = way_of(pred ? line_h : line_s, fp);
        end else if (fo >= 0) begin
            e_hit = 1; e_huge = !pred; e_second = 1; exp_reads = 2;
            e = way_of(pred ? line_s : line_h, fo);
        end else begin
            e_hit = 0; e_huge = !pred; e_second = 1; exp_reads = 2;
        end
        reads = 0;
        req_vpn = v; req_asid = a; req_vmid = m; req_huge_pred = pred;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk({tag, " R9 busy req_ready"}, 64'(req_ready), 64'd0);
        waited = 0;
        while (!rsp_valid && waited < 200) begin
            @(negedge clk);
            waited++;
        end
        chk({tag, " R9 response arrives"}, 64'(rsp_valid), 64'd1);
        s_ppn = rsp_ppn;
        repeat ($urandom() % 3) @(negedge clk);
        chk({tag, " R9 held ppn"}, 64'(rsp_ppn), 64'(s_ppn));
        chk({tag, " R5 R6 R7 hit"}, 64'(rsp_hit), 64'(e_hit));
        chk({tag, " R7 walk"}, 64'(rsp_walk), 64'(!e_hit));
        chk({tag, " R6 second"}, 64'(rsp_second), 64'(e_second));
        chk({tag, " R4 reads"}, 64'(reads), 64'(exp_reads));
        chk({tag, " R3 R5 first addr"}, 64'(rec_addr[0]), 64'(exp_addr(v, pred)));
        if (exp_reads == 2)
            chk({tag, " R3 R6 second addr"}, 64'(rec_addr[1]), 64'(exp_addr(v, !pred)));
        if (e_hit) begin
            chk({tag, " R8 huge"}, 64'(rsp_huge), 64'(e_huge));
            chk({tag, " R8 ppn"}, 64'(rsp_ppn), 64'(e.ppn));
            chk({tag, " R8 attr"}, 64'(rsp_attr), 64'(e.attr));
        end
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        chk({tag, " R9 response drops"}, 64'(rsp_valid), 64'd0);
        chk({tag, " R9 idle again"}, 64'(req_ready), 64'd1);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [35:0] v;
        logic [15:0] a, m;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; req_valid = 1'b0; rsp_ready = 1'b0;
        req_vpn = '0; req_asid = '0; req_vmid = '0; req_huge_pred = 1'b0;
        line_s = '0; line_h = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 reset req_ready", 64'(req_ready), 64'd1);
        chk("R9 reset rsp_valid", 64'(rsp_valid), 64'd0);
        chk("R9 reset mem_req_valid", 64'(mem_req_valid), 64'd0);

        v = 36'h9_8765_4321; a = 16'h1111; m = 16'h2222;

        // R5: predicted small class hits way 2.
        fill_random();
        line_s[2*ENTRY_W +: ENTRY_W] = mk(1, m, a, 19'h5A5A5, 40'hAB_CDEF_0123, v);
        run(v, a, m, 1'b0, "R5 small hit");

        // R6 R1: small misses, huge hits with different low VPN bits.
        fill_random();
        line_h[1*ENTRY_W +: ENTRY_W] = mk(1, m, a, 19'h12345, 40'h11_2233_4455, v ^ 36'h1FF);
        run(v, a, m, 1'b0, "R6 huge second");

        // R5: both classes hold a match, prediction huge, one read.
        fill_random();
        line_s[0 +: ENTRY_W] = mk(1, m, a, 19'h1, 40'h1, v);
        line_h[3*ENTRY_W +: ENTRY_W] = mk(1, m, a, 19'h2, 40'h2, v);
        run(v, a, m, 1'b1, "R5 both pred huge");

        // R7: both miss.
        fill_random();
        run(v, a, m, 1'b1, "R7 walk");

        // R1: decoys with invalid, wrong ASID, wrong VMID; real match in way 3.
        fill_random();
        line_s[0 +: ENTRY_W]         = mk(0, m, a, 19'h3, 40'h3, v);
        line_s[1*ENTRY_W +: ENTRY_W] = mk(1, m, a ^ 16'h1, 19'h4, 40'h4, v);
        line_s[2*ENTRY_W +: ENTRY_W] = mk(1, m ^ 16'h8000, a, 19'h5, 40'h5, v);
        line_s[3*ENTRY_W +: ENTRY_W] = mk(1, m, a, 19'h6, 40'h6, v);
        run(v, a, m, 1'b0, "R1 decoys");

        // R2: duplicate matches at ways 1 and 3, way 1 must win.
        fill_random();
        line_h[1*ENTRY_W +: ENTRY_W] = mk(1, m, a, 19'h7, 40'h77, v);
        line_h[3*ENTRY_W +: ENTRY_W] = mk(1, m, a, 19'h8, 40'h88, v);
        run(v, a, m, 1'b1, "R2 lowest way");

        // R1: small class entry differs only in VPN bit 0, so it must miss.
        fill_random();
        line_s[0 +: ENTRY_W] = mk(1, m, a, 19'h9, 40'h99, v ^ 36'h1);
        run(v, a, m, 1'b0, "R1 small low bit");

        // R3: top set index in both classes.
        fill_random();
        run(36'h0_0007_FFFF, a, m, 1'b1, "R3 max index");

        // Random lookups with random placement and decoys.
        for (int i = 0; i < 300; i++) begin
            int k, ws, wh;
            v = rnd36(); a = 16'($urandom()); m = 16'($urandom());
            fill_random();
            k = $urandom() % 4; ws = $urandom() % 4; wh = $urandom() % 4;
            if (k == 1 || k == 3)
                line_s[ws*ENTRY_W +: ENTRY_W] = mk(1, m, a, 19'($urandom()), 40'($urandom()), v);
            if (k == 2 || k == 3)
                line_h[wh*ENTRY_W +: ENTRY_W] = mk(1, m, a, 19'($urandom()), 40'($urandom()),
                                                   {v[35:9], 9'($urandom())});
            if ($urandom() % 2 == 1)
                line_s[($urandom() % 4)*ENTRY_W +: ENTRY_W] = mk(0, m, a, 19'h0, 40'h0, v);
            run(v, a, m, 1'($urandom()), "R1 R2 R5 R6 R7 R8 random");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule